// File: doc/BRIEF.md
# Receive Endpoint Packet Buffer Controller

This block holds received packets for one OUT endpoint of a device-side serial bus controller. A packet engine in front of it delivers bytes one per cycle with a valid strobe and marks the final byte with an end-of-packet flag. A processor-side reader unloads the packet at the head byte by byte, sees the head packet's length, and then releases the slot by clearing the ready flag. The block depends on a programmed maximum packet size, an auto-release enable and a two-packet disable bit. From these it decides whether one or two packets can be held, and whether each arriving packet is stored, refused or dropped as overlong.

The byte store of `DEPTH` entries is used whole in one-packet mode. In two-packet mode it is split into two halves that are used in turn. Ready and full flags, a one-cycle interrupt pulse on every rise of ready, and one-cycle store/refuse pulses tell the two sides what happened. Refusal stands in for a negative acknowledge to the host.

Top module: `rx_ep_buf`

## Requirements
- R1: After reset, ready, full, irq, overrun, accept and refuse are 0. The settings reset to max size `DEPTH`, auto-release off and two-packet disable set, so one-packet mode is used.
- R2: Two-packet mode is used only when the disable bit is 0, the max size is nonzero and twice the max size is at most `DEPTH`. The mode is re-evaluated only in a cycle where no packet is stored, no byte arrives, no packet is partly received and no re-raise is pending.
- R3: In one-packet mode, storing a packet raises ready and full in the cycle after its end-of-packet byte.
- R4: In two-packet mode, the first stored packet raises ready with full left at 0. Full rises only when a second packet is stored.
- R5: A packet whose first byte arrives while the number of stored packets equals the capacity (1 or 2) is discarded whole. A refuse pulse follows its end-of-packet byte, and ready, full and the head count stay as they were.
- R6: A packet longer than the max size, or longer than its slot (`DEPTH/2` in two-packet mode, `DEPTH` otherwise), is dropped without a refuse pulse and sets the sticky overrun flag. `ovr_clr` clears the flag; a new overrun in the same cycle wins.
- R7: While ready is 1, `rd_cnt` shows the head packet's length and `rd_data` shows its byte at the read index. The index starts at 0 and `rd_en` advances it while it is below the length. While ready is 0, `rd_cnt` is 0.
- R8: `clr_ready` while ready is 1 releases the head packet, and ready drops in the next cycle. While ready is 0 it has no effect.
- R9: Releasing the head while two packets are held drops full and ready together for one cycle. Ready then rises again with an irq pulse, and `rd_cnt` shows the second packet's length.
- R10: With auto-release on, reading the last byte of a packet whose length equals the max size releases it as in R8. Shorter packets stay ready after their last byte.
- R11: `cfg_err` is 1 exactly when the programmed max size is 0 or larger than `DEPTH`.
- R12: `irq` is a one-cycle pulse in the first cycle of every rise of ready.
- R13: `accept` pulses for one cycle, together with the rise of ready or full, after a packet is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the three settings below |
| cfg_max | input | CW | Maximum packet size in bytes |
| cfg_auto | input | 1 | Auto-release enable |
| cfg_dbl_off | input | 1 | Two-packet disable (1 = one packet only) |
| wr_valid | input | 1 | Incoming byte valid |
| wr_data | input | DW | Incoming byte |
| wr_eop | input | 1 | Marks the valid byte as the last of its packet |
| rd_en | input | 1 | Reader consumes the byte on rd_data |
| clr_ready | input | 1 | Reader releases the head packet |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | DW | Head packet byte at the read index |
| rd_cnt | output | CW | Head packet length while ready, else 0 |
| ready | output | 1 | A packet is available to the reader |
| full | output | 1 | Every slot is occupied |
| irq | output | 1 | One-cycle pulse on each rise of ready |
| overrun | output | 1 | Sticky flag for a dropped overlong packet |
| accept | output | 1 | One-cycle pulse: packet stored |
| refuse | output | 1 | One-cycle pulse: packet refused for lack of a slot |
| cfg_err | output | 1 | Max size setting is invalid |

## Verification
The bench builds the block with `DEPTH` = 16, which gives a 5-bit count and 8-byte halves. With that size, max sizes of 4, 8 and 9 straddle the two-packet threshold, and a 10-byte packet crosses the 9-byte limit. Settings of 0 and 20 reach the invalid-setting flag. The small store also lets a few short packets fill both slots, so refusal, the one-cycle re-raise and the held-mode rule are all reached within a few hundred cycles.

// File: rtl/rx_ep_pkg.sv
package rx_ep_pkg;

  // Two packets fit only when enabled and twice the max size fits the store.
  function automatic bit dual_ok(input int unsigned maxp, input int unsigned depth,
                                 input bit dis);
    return !dis && (maxp != 0) && (2 * maxp <= depth);
  endfunction

  // Bytes one slot may hold in the current mode.
  function automatic int unsigned slot_room(input bit dual, input int unsigned depth);
    return dual ? depth / 2 : depth;
  endfunction

  // First store address of a slot.
  function automatic int unsigned slot_base(input bit dual, input bit slot,
                                            input int unsigned depth);
    return (dual && slot) ? depth / 2 : 0;
  endfunction

endpackage

// File: rtl/rx_ep_store.sv
module rx_ep_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          cnt_we,
  input  logic          cnt_slot,
  input  logic [CW-1:0] cnt_val,
  input  logic          head_slot,
  output logic [CW-1:0] head_cnt
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // One length register per slot.
  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [CW-1:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           len_q <= '0;
      else if (cnt_we && cnt_slot == 1'(s)) len_q <= cnt_val;
    end
  end

  assign head_cnt = head_slot ? g_slot[1].len_q : g_slot[0].len_q;

endmodule

// File: rtl/rx_ep_ingest.sv
module rx_ep_ingest
  import rx_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_eop,
  input  logic [DW-1:0] wr_data,
  input  logic          room_ok,
  input  logic          dual,
  input  logic          tail,
  input  logic [CW-1:0] max_len,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          acc_evt,
  output logic          ref_evt,
  output logic          ovr_evt,
  output logic [CW-1:0] pkt_len
);

  localparam logic [CW-1:0] LEN_SAT = CW'(DEPTH + 1);

  logic          busy_q, take_q;
  logic [CW-1:0] len_q, len_now, room;
  logic          take_now, fits, too_long, eop;

  always_comb begin
    room = CW'(slot_room(dual, DEPTH));
    if (!busy_q)              len_now = CW'(1);
    else if (len_q == LEN_SAT) len_now = LEN_SAT;
    else                      len_now = len_q + 1'b1;
    // Admission is decided once, at the first byte of a packet.
    take_now = busy_q ? take_q : room_ok;
    fits     = (len_now <= room);
    too_long = (len_now > max_len) || !fits;
    eop      = wr_valid && wr_eop;
  end

  assign mem_we   = wr_valid && take_now && fits;
  assign mem_addr = AW'(slot_base(dual, tail, DEPTH)) + AW'(len_now - 1'b1);
  assign mem_data = wr_data;
  assign ovr_evt  = eop && too_long;
  assign ref_evt  = eop && !too_long && !take_now;
  assign acc_evt  = eop && !too_long && take_now;
  assign pkt_len  = len_now;
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      take_q <= 1'b0;
      len_q  <= '0;
    end else if (wr_valid) begin
      busy_q <= !wr_eop;
      take_q <= take_now;
      len_q  <= wr_eop ? '0 : len_now;
    end
  end

endmodule

// File: rtl/rx_ep_slots.sv
module rx_ep_slots (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_evt,
  input  logic       clr_evt,
  input  logic       wr_active,
  input  logic       mode_req,
  output logic       ready,
  output logic       full,
  output logic       irq,
  output logic [1:0] npk,
  output logic       dual,
  output logic       head,
  output logic       tail
);

  logic [1:0] npk_q, npk_n, cap;
  logic       ready_q, ready_n, rearm_q, rearm_n, full_q, irq_q;
  logic       dual_q, head_q, tail_q, mode_idle;

  always_comb begin
    cap   = dual_q ? 2'd2 : 2'd1;
    npk_n = npk_q - {1'b0, clr_evt} + {1'b0, acc_evt};
    rearm_n = 1'b0;
    if (clr_evt) begin
      ready_n = 1'b0;
      rearm_n = (npk_n != 2'd0);
    end else if (rearm_q || (acc_evt && npk_q == 2'd0)) begin
      ready_n = 1'b1;
    end else begin
      ready_n = ready_q;
    end
    mode_idle = (npk_q == 2'd0) && !wr_active && !rearm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npk_q   <= 2'd0;
      ready_q <= 1'b0;
      rearm_q <= 1'b0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      dual_q  <= 1'b0;
      head_q  <= 1'b0;
      tail_q  <= 1'b0;
    end else begin
      npk_q   <= npk_n;
      ready_q <= ready_n;
      rearm_q <= rearm_n;
      full_q  <= (npk_n == cap);
      irq_q   <= ready_n && !ready_q;
      if (mode_idle)          dual_q <= mode_req;
      if (clr_evt && dual_q)  head_q <= !head_q;
      if (acc_evt && dual_q)  tail_q <= !tail_q;
    end
  end

  assign ready = ready_q;
  assign full  = full_q;
  assign irq   = irq_q;
  assign npk   = npk_q;
  assign dual  = dual_q;
  assign head  = head_q;
  assign tail  = tail_q;

endmodule

// File: rtl/rx_ep_buf.sv
module rx_ep_buf
  import rx_ep_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int CW    = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_max,
  input  logic          cfg_auto,
  input  logic          cfg_dbl_off,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eop,
  input  logic          rd_en,
  input  logic          clr_ready,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_cnt,
  output logic          ready,
  output logic          full,
  output logic          irq,
  output logic          overrun,
  output logic          accept,
  output logic          refuse,
  output logic          cfg_err
);

  localparam int AW = $clog2(DEPTH);

  // Settings
  logic [CW-1:0] max_q;
  logic          auto_q, dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q  <= CW'(DEPTH);
      auto_q <= 1'b0;
      dis_q  <= 1'b1;
    end else if (cfg_we) begin
      max_q  <= cfg_max;
      auto_q <= cfg_auto;
      dis_q  <= cfg_dbl_off;
    end
  end

  // Named internal events
  logic          acc_evt, ref_evt, ovr_evt, clr_evt, rd_fire, auto_hit;
  logic          ing_busy, mem_we, dual, head, tail, mode_req, room_ok;
  logic [1:0]    npk;
  logic [AW-1:0] mem_addr, raddr;
  logic [DW-1:0] mem_data;
  logic [CW-1:0] pkt_len, head_cnt, rd_ptr;

  assign mode_req = dual_ok(32'(max_q), DEPTH, dis_q);
  assign room_ok  = (npk < (dual ? 2'd2 : 2'd1));
  assign cfg_err  = (max_q == '0) || (max_q > CW'(DEPTH));

  rx_ep_ingest #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) ingest_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_eop(wr_eop), .wr_data(wr_data),
    .room_ok(room_ok), .dual(dual), .tail(tail), .max_len(max_q), .busy(ing_busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .acc_evt(acc_evt),
    .ref_evt(ref_evt), .ovr_evt(ovr_evt), .pkt_len(pkt_len)
  );

  rx_ep_slots slots_i (
    .clk(clk), .rst_n(rst_n), .acc_evt(acc_evt), .clr_evt(clr_evt),
    .wr_active(ing_busy || wr_valid), .mode_req(mode_req), .ready(ready), .full(full),
    .irq(irq), .npk(npk), .dual(dual), .head(head), .tail(tail)
  );

  rx_ep_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) store_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
    .raddr(raddr), .rdata(rd_data), .cnt_we(acc_evt), .cnt_slot(tail),
    .cnt_val(pkt_len), .head_slot(head), .head_cnt(head_cnt)
  );

  // Read side
  assign rd_fire  = rd_en && ready && (rd_ptr < head_cnt);
  assign auto_hit = rd_fire && auto_q && (head_cnt == max_q) && (rd_ptr + 1'b1 == head_cnt);
  assign clr_evt  = ready && (clr_ready || auto_hit);
  assign raddr    = AW'(slot_base(dual, head, DEPTH)) + AW'(rd_ptr);
  assign rd_cnt   = ready ? head_cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_ptr <= '0;
    else if (clr_evt) rd_ptr <= '0;
    else if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
  end

  // Status pulses and sticky overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      accept  <= 1'b0;
      refuse  <= 1'b0;
    end else begin
      accept <= acc_evt;
      refuse <= ref_evt;
      if (ovr_evt)      overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_ep_buf_chk.sv
module rx_ep_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       full,
  input logic       irq,
  input logic       overrun,
  input logic       accept,
  input logic       refuse,
  input logic       clr_evt,
  input logic [1:0] npk,
  input logic       dual,
  input logic       wr_valid,
  input logic       wr_eop
);

  // R12
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R12
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ready);
  // R8
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_evt |=> !ready);
  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && npk == 2'd2) |=> (!ready && !full) ##1 ready);
  // R4
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> ready);
  // R3
  single_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && ready) |-> full);
  // R5
  refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) refuse |-> !accept);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (npk != 2'd0) |=> $stable(dual));
  // R6
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wr_valid && wr_eop));

endmodule

bind rx_ep_buf rx_ep_buf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .full(full), .irq(irq), .overrun(overrun),
  .accept(accept), .refuse(refuse), .clr_evt(clr_evt), .npk(npk), .dual(dual),
  .wr_valid(wr_valid), .wr_eop(wr_eop)
);

// File: tb/rx_ep_buf_tb_top.sv
module rx_ep_buf_tb_top;

  localparam int TB_DEPTH  = 16;
  localparam int TB_CW     = $clog2(TB_DEPTH + 2);
  localparam int CLK_PER   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_auto = 0, cfg_dbl_off = 0;
  logic [TB_CW-1:0] cfg_max = '0;
  logic wr_valid = 0, wr_eop = 0, rd_en = 0, clr_ready = 0, ovr_clr = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [TB_CW-1:0] rd_cnt;
  logic ready, full, irq, overrun, accept, refuse, cfg_err;

  always #(CLK_PER/2) clk = ~clk;

  rx_ep_buf #(.DEPTH(TB_DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_max(cfg_max), .cfg_auto(cfg_auto),
    .cfg_dbl_off(cfg_dbl_off), .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop),
    .rd_en(rd_en), .clr_ready(clr_ready), .ovr_clr(ovr_clr), .rd_data(rd_data),
    .rd_cnt(rd_cnt), .ready(ready), .full(full), .irq(irq), .overrun(overrun),
    .accept(accept), .refuse(refuse), .cfg_err(cfg_err)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int plen[$];
  logic [7:0] pdata[$];
  logic [7:0] cur[$];
  int  curlen, rdidx, mmax, np, cap, lim;
  bit  mauto, mdis, mdual, mready, mrearm, mfull, mirq, movr, macc, mref;
  bit  mbusy, mtake, clr, ovr_set, was_busy, was_rearm, was_ready;

  always @(posedge clk) begin
    if (!rst_n) begin
      plen.delete(); pdata.delete(); cur.delete();
      curlen = 0; rdidx = 0; mmax = TB_DEPTH; mauto = 0; mdis = 1; mdual = 0;
      mready = 0; mrearm = 0; mfull = 0; mirq = 0; movr = 0; macc = 0; mref = 0;
      mbusy = 0; mtake = 0;
    end else begin
      np = plen.size(); cap = mdual ? 2 : 1; lim = mdual ? TB_DEPTH/2 : TB_DEPTH;
      was_busy = mbusy; was_rearm = mrearm; was_ready = mready;
      clr = 0; ovr_set = 0; macc = 0; mref = 0;
      if (mready) begin
        if (clr_ready) clr = 1;
        else if (rd_en && rdidx < plen[0]) begin
          rdidx++;
          if (mauto && plen[0] == mmax && rdidx == plen[0]) clr = 1;
        end
      end
      if (wr_valid) begin
        if (!mbusy) begin mtake = (np < cap); curlen = 0; cur.delete(); end
        curlen++;
        if (curlen <= lim) cur.push_back(wr_data);
        mbusy = !wr_eop;
        if (wr_eop) begin
          if (curlen > mmax || curlen > lim) ovr_set = 1;
          else if (!mtake) mref = 1;
          else macc = 1;
        end
      end
      if (clr) begin
        for (int i = 0; i < plen[0]; i++) void'(pdata.pop_front());
        void'(plen.pop_front());
        rdidx = 0;
      end
      if (macc) begin
        plen.push_back(curlen);
        foreach (cur[i]) pdata.push_back(cur[i]);
      end
      if (clr) begin mready = 0; mrearm = (plen.size() > 0); end
      else if (was_rearm) begin mready = 1; mrearm = 0; end
      else if (macc && np == 0) mready = 1;
      mfull = (plen.size() == cap);
      mirq = mready && !was_ready;
      if (ovr_set) movr = 1; else if (ovr_clr) movr = 0;
      if (np == 0 && !was_busy && !wr_valid && !was_rearm)
        mdual = !mdis && mmax != 0 && 2 * mmax <= TB_DEPTH;
      if (cfg_we) begin mmax = int'(cfg_max); mauto = cfg_auto; mdis = cfg_dbl_off; end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      expect_eq("R3 ready vs model", int'(ready), int'(mready));
      expect_eq("R4 full vs model", int'(full), int'(mfull));
      expect_eq("R12 irq vs model", int'(irq), int'(mirq));
      expect_eq("R6 overrun vs model", int'(overrun), int'(movr));
      expect_eq("R13 accept vs model", int'(accept), int'(macc));
      expect_eq("R5 refuse vs model", int'(refuse), int'(mref));
      expect_eq("R11 cfg_err vs model", int'(cfg_err), int'(mmax == 0 || mmax > TB_DEPTH));
      expect_eq("R7 rd_cnt vs model", int'(rd_cnt), mready ? plen[0] : 0);
      if (mready && rdidx < plen[0])
        expect_eq("R7 rd_data vs model", int'(rd_data), int'(pdata[rdidx]));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_pkt(input int n, input logic [7:0] b0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_data = b0 + 8'(i); wr_eop = (i == n - 1);
    end
    @(negedge clk);
    wr_valid = 0; wr_eop = 0;
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 1;
    end
    @(negedge clk); rd_en = 0;
  endtask

  task automatic release_head();
    @(negedge clk); clr_ready = 1;
    @(negedge clk); clr_ready = 0;
  endtask

  task automatic set_cfg(input int mx, input bit au, input bit dis);
    @(negedge clk);
    cfg_we = 1; cfg_max = TB_CW'(mx); cfg_auto = au; cfg_dbl_off = dis;
    @(negedge clk); cfg_we = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    expect_eq("R1 ready after reset", int'(ready), 0);
    expect_eq("R1 full after reset", int'(full), 0);
    expect_eq("R1 overrun after reset", int'(overrun), 0);
    expect_eq("R11 default max valid", int'(cfg_err), 0);

    // One-packet mode by default (R1, R3)
    send_pkt(5, 8'h10);
    expect_eq("R3 ready after store", int'(ready), 1);
    expect_eq("R3 full after store", int'(full), 1);
    expect_eq("R12 irq on ready rise", int'(irq), 1);
    expect_eq("R13 accept pulse", int'(accept), 1);
    send_pkt(3, 8'h40);
    expect_eq("R5 refuse pulse", int'(refuse), 1);
    expect_eq("R5 head count kept", int'(rd_cnt), 5);
    read_n(2);
    expect_eq("R7 third byte", int'(rd_data), 8'h12);
    release_head();
    expect_eq("R8 ready dropped", int'(ready), 0);
    expect_eq("R8 full dropped", int'(full), 0);
    release_head();
    expect_eq("R8 clear ignored when idle", int'(ready), 0);
    expect_eq("R7 count zero when idle", int'(rd_cnt), 0);

    // Two-packet mode with auto-release (R4, R9, R10)
    set_cfg(8, 1, 0);
    send_pkt(8, 8'h20);
    expect_eq("R4 first packet ready", int'(ready), 1);
    expect_eq("R4 first packet not full", int'(full), 0);
    send_pkt(3, 8'h30);
    expect_eq("R4 second packet full", int'(full), 1);
    send_pkt(2, 8'h70);
    expect_eq("R5 refuse when both held", int'(refuse), 1);
    read_n(7);
    expect_eq("R10 still ready before last", int'(ready), 1);
    read_n(1);
    expect_eq("R10 auto release ready low", int'(ready), 0);
    expect_eq("R9 full cleared", int'(full), 0);
    idle(1);
    expect_eq("R9 ready re-raised", int'(ready), 1);
    expect_eq("R9 irq on re-raise", int'(irq), 1);
    expect_eq("R9 second count", int'(rd_cnt), 3);
    expect_eq("R9 second data", int'(rd_data), 8'h30);
    read_n(3);
    expect_eq("R10 short packet stays", int'(ready), 1);
    release_head();
    expect_eq("R8 manual release", int'(ready), 0);

    // Max size too large for two packets (R2)
    set_cfg(9, 0, 0);
    send_pkt(4, 8'h80);
    expect_eq("R2 one packet mode full", int'(full), 1);
    send_pkt(4, 8'h90);
    expect_eq("R2 second refused", int'(refuse), 1);
    release_head();

    // Overlong packet (R6)
    send_pkt(10, 8'hA0);
    expect_eq("R6 overrun set", int'(overrun), 1);
    expect_eq("R6 not ready", int'(ready), 0);
    expect_eq("R6 no refuse", int'(refuse), 0);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    expect_eq("R6 overrun cleared", int'(overrun), 0);

    // Invalid settings (R11)
    set_cfg(20, 0, 1);
    expect_eq("R11 max above depth", int'(cfg_err), 1);
    set_cfg(0, 0, 1);
    expect_eq("R11 max zero", int'(cfg_err), 1);

    // Mode held while a packet is stored (R2), manual re-raise (R9)
    set_cfg(16, 0, 1);
    send_pkt(2, 8'hB0);
    set_cfg(4, 0, 0);
    send_pkt(2, 8'hC0);
    expect_eq("R2 mode held while stored", int'(refuse), 1);
    release_head();
    idle(1);
    send_pkt(2, 8'h50);
    expect_eq("R2 new mode first not full", int'(full), 0);
    send_pkt(2, 8'h60);
    expect_eq("R2 new mode second full", int'(full), 1);
    release_head();
    expect_eq("R9 manual gap", int'(ready), 0);
    idle(1);
    expect_eq("R9 manual re-raise", int'(ready), 1);
    expect_eq("R9 queued data", int'(rd_data), 8'h60);
    release_head();
    idle(2);
    finish_run();
  end

endmodule